// File: doc/BRIEF.md
# Clock-Generator Output-Enable Control Slave

This block is the two-wire serial control port of a multi-output clock generator. It oversamples the bus clock and data lines with a faster system clock, detects START and STOP conditions, responds only to the 7-bit device address 1101001, and holds two enable bytes. Their bits are presented as parallel enable signals for eight buffer outputs, one CPU clock, two ASIC clocks and four PCI clocks.

Transfers are block-style. A write, which uses address byte 0xD2, carries a command byte and a byte-count byte. The slave acknowledges both and then discards them. The data bytes that follow fill the enable bytes in ascending order. A read, which uses address byte 0xD3, first returns the stored byte count (0x09) and then the enable bytes in ascending order. The slave never stretches the clock. It drives the data line as an open-drain pad: one output selects "pull low" and the data value it drives is always 0.

The controller has seven states:

- `ST_IDLE`: waiting for a START.
- `ST_ADDR`: shifting in the address byte.
- `ST_ACK_ADDR`: acknowledging a matching address.
- `ST_RX`: shifting in a written byte.
- `ST_ACK_RX`: acknowledging that byte.
- `ST_TX`: shifting out a read byte.
- `ST_ACK_TX`: sampling the master's acknowledge.

Transitions:

- `ST_IDLE` to `ST_ADDR` on START.
- `ST_ADDR` to `ST_ACK_ADDR` when the address matches. `ST_ADDR` to `ST_IDLE` when it does not.
- `ST_ACK_ADDR` to `ST_RX` for a write, or to `ST_TX` for a read.
- `ST_RX` to `ST_ACK_RX` after 8 bits, then back to `ST_RX`.
- `ST_TX` to `ST_ACK_TX` after 8 bits.
- `ST_ACK_TX` to `ST_TX` on a master ACK, or to `ST_IDLE` on a NACK.
- Any state to `ST_ADDR` on START, and any state to `ST_IDLE` on STOP.

Top module: `clkgen_i2c_ctrl`

## Requirements
- R1: After reset all fifteen enable outputs are 1 and `sda_oe` is 0.
- R2: Only the address bytes 0xD2 (write) and 0xD3 (read) are acknowledged. Any other address byte gets no ACK, and the slave stays silent and unchanged until the next START.
- R3: In a write, the first two bytes after the address (command and byte count) are acknowledged and have no effect on any output. The third byte loads enable byte 0 and the fourth loads enable byte 1.
- R4: Bit k (k = 0..7) of enable byte 0 drives `buf_en[k]`, where 1 means enabled.
- R5: In enable byte 1, bit 6 drives `cpu_en`, bits 5:4 drive `asic_en[1:0]` and bits 3:0 drive `pci_en[3:0]`. Bit 7 cannot be written and reads back as 0.
- R6: A read returns 0x09 first, then enable byte 0, then enable byte 1, and 0x00 for every later byte. Bytes are sent MSB first.
- R7: Written data bytes beyond enable byte 1 are acknowledged and discarded.
- R8: If the master does not acknowledge a read byte, the slave releases SDA and ignores further SCL pulses until the next START.
- R9: A START at any point begins a new address phase, and a STOP at any point returns the slave to idle with SDA released.
- R10: The slave changes `sda_oe` only while synchronized SCL is low.
- R11: The enable outputs change only in the cycle after a data byte to enable byte 0 or 1 completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_o | output | 1 | Value driven onto SDA when enabled (always 0) |
| sda_oe | output | 1 | 1 = pull SDA low |
| buf_en | output | 8 | Buffer output enables |
| cpu_en | output | 1 | CPU clock enable |
| asic_en | output | 2 | ASIC clock enables |
| pci_en | output | 4 | PCI clock enables |

## Verification
An error in the bit counter or the byte index appears on SDA within one byte time. Possible symptoms are an ACK slot with no acknowledge, a read byte that is shifted by a bit, or the byte count appearing somewhere other than first. An error in the register path appears on the enable outputs one cycle after the eighth bit of the data byte falls. Walking-one and walking-zero patterns through both bytes, each followed by a full read-back, pin every bit position to its output. A sweep over all 128 addresses exposes a wrong address match at the ACK slot of the address byte.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_ADDR,
        ST_RX,
        ST_ACK_RX,
        ST_TX,
        ST_ACK_TX
    } ctl_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_ff, sda_ff;
    logic              scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            scl_q  <= scl_ff[STAGES-1];
            sda_q  <= sda_ff[STAGES-1];
        end
    end

    assign scl_s     = scl_ff[STAGES-1];
    assign sda_s     = sda_ff[STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    // data edges while the clock stays high
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/clkctl_regs.sv
module clkctl_regs #(
    parameter int                  NREG  = 2,
    parameter int                  DW    = 8,
    parameter int                  SEL_W = 4,
    parameter logic [NREG*DW-1:0]  WMASK = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [DW-1:0]      wr_data,
    input  logic [SEL_W-1:0]   rd_sel,
    output logic [DW-1:0]      rd_data,
    output logic [NREG*DW-1:0] regs_o
);
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam logic [DW-1:0] MASK = WMASK[i*DW +: DW];
        logic [DW-1:0] r;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                r <= MASK;
            else if (wr_en && wr_sel == SEL_W'(i))
                r <= wr_data & MASK;
        end

        assign regs_o[i*DW +: DW] = r;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++)
            if (rd_sel == SEL_W'(i))
                rd_data = regs_o[i*DW +: DW];
    end
endmodule

// File: rtl/clkgen_i2c_ctrl.sv
module clkgen_i2c_ctrl
    import clkctl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'b1101001,
    parameter logic [7:0] BCOUNT_RST  = 8'h09,
    parameter int         SYNC_STAGES = 2,
    parameter int         IDX_W       = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_o,
    output logic       sda_oe,
    output logic [7:0] buf_en,
    output logic       cpu_en,
    output logic [1:0] asic_en,
    output logic [3:0] pci_en
);
    localparam int                NREG    = 2;
    localparam int                DW      = 8;
    localparam logic [IDX_W-1:0]  IDX_MAX = '1;
    localparam logic [IDX_W-1:0]  WR_BASE = IDX_W'(2);

    ctl_state_e          state, nxt;
    logic                scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [7:0]          sh;
    logic [2:0]          bitcnt;
    logic                phase;
    logic                rw;
    logic [IDX_W-1:0]    idx;
    logic                wr_en;
    logic [DW-1:0]       reg_rd, tx_byte;
    logic [NREG*DW-1:0]  regs;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    clkctl_regs #(
        .NREG  (NREG),
        .DW    (DW),
        .SEL_W (IDX_W),
        .WMASK (16'h7FFF)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (idx - WR_BASE),
        .wr_data (sh),
        .rd_sel  (idx - IDX_W'(1)),
        .rd_data (reg_rd),
        .regs_o  (regs)
    );

    // read slot 0 carries the byte count, later slots the enable bytes
    assign tx_byte = (idx == '0) ? BCOUNT_RST : reg_rd;

    function automatic logic [IDX_W-1:0] sat_inc(input logic [IDX_W-1:0] v);
        return (v == IDX_MAX) ? v : v + IDX_W'(1);
    endfunction

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state decode
    always_comb begin
        nxt = state;
        if (start_det)
            nxt = ST_ADDR;
        else if (stop_det)
            nxt = ST_IDLE;
        else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_ADDR:     if (scl_fall && phase)
                                 nxt = (sh[7:1] == DEV_ADDR) ? ST_ACK_ADDR : ST_IDLE;
                ST_ACK_ADDR: if (scl_fall) nxt = rw ? ST_TX : ST_RX;
                ST_RX:       if (scl_fall && phase) nxt = ST_ACK_RX;
                ST_ACK_RX:   if (scl_fall) nxt = ST_RX;
                ST_TX:       if (scl_fall && bitcnt == 3'd7) nxt = ST_ACK_TX;
                ST_ACK_TX:   if (scl_rise && sda_s) nxt = ST_IDLE;
                             else if (scl_fall && phase) nxt = ST_TX;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // shift register, bit counter and byte index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh     <= '0;
            bitcnt <= '0;
            phase  <= 1'b0;
            rw     <= 1'b0;
            idx    <= '0;
        end else if (start_det) begin
            bitcnt <= '0;
            phase  <= 1'b0;
            idx    <= '0;
        end else begin
            unique case (state)
                ST_ADDR, ST_RX: begin
                    if (scl_rise) begin
                        sh     <= {sh[6:0], sda_s};
                        bitcnt <= bitcnt + 3'd1;
                        if (bitcnt == 3'd7) phase <= 1'b1;
                    end
                    if (scl_fall && phase) begin
                        phase <= 1'b0;
                        if (state == ST_ADDR) rw <= sh[0];
                    end
                end
                ST_ACK_ADDR: if (scl_fall && rw) sh <= tx_byte;
                ST_ACK_RX:   if (scl_fall) idx <= sat_inc(idx);
                ST_TX: if (scl_fall) begin
                    sh     <= {sh[6:0], 1'b0};
                    bitcnt <= bitcnt + 3'd1;
                    if (bitcnt == 3'd7) idx <= sat_inc(idx);
                end
                ST_ACK_TX: begin
                    if (scl_rise && !sda_s) phase <= 1'b1;
                    if (scl_fall && phase) begin
                        phase <= 1'b0;
                        sh    <= tx_byte;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_oe = 1'b0;
        wr_en  = 1'b0;
        unique case (state)
            ST_ACK_ADDR, ST_ACK_RX: sda_oe = 1'b1;
            ST_TX:                  sda_oe = ~sh[7];
            ST_RX:                  wr_en  = scl_fall && phase && !start_det &&
                                             !stop_det && (idx >= WR_BASE);
            default: ;
        endcase
    end

    assign sda_o   = 1'b0;
    assign buf_en  = regs[7:0];
    assign cpu_en  = regs[14];
    assign asic_en = regs[13:12];
    assign pci_en  = regs[11:8];
endmodule

// File: rtl/clkgen_i2c_ctrl_chk.sv
module clkgen_i2c_ctrl_chk
    import clkctl_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input ctl_state_e  state,
    input logic        scl_s,
    input logic        start_det,
    input logic        stop_det,
    input logic        sda_oe,
    input logic        wr_en,
    input logic [14:0] en_vec
);
    // R9
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE && !sda_oe));

    // R10
    sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s) && !$past(start_det) && !$past(stop_det))
        |-> $stable(sda_oe));

    // R11
    en_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(en_vec));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);

    // R11
    wr_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (state == ST_RX && !scl_s));
endmodule

bind clkgen_i2c_ctrl clkgen_i2c_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .scl_s     (scl_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe),
    .wr_en     (wr_en),
    .en_vec    ({cpu_en, asic_en, pci_en, buf_en})
);

// File: tb/test_clkgen_i2c_ctrl.sv
module test_clkgen_i2c_ctrl;
    localparam int Q = 6;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_o, sda_oe, cpu_en;
    logic [7:0] buf_en;
    logic [1:0] asic_en;
    logic [3:0] pci_en;
    logic       sda_bus;

    assign sda_bus = sda_m & ~sda_oe;

    clkgen_i2c_ctrl i_clkgen_i2c_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_m),
        .sda_i   (sda_bus),
        .sda_o   (sda_o),
        .sda_oe  (sda_oe),
        .buf_en  (buf_en),
        .cpu_en  (cpu_en),
        .asic_en (asic_en),
        .pci_en  (pci_en)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; idle(Q);
        scl_m = 1'b1; idle(Q);
        sda_m = 1'b0; idle(Q);
        scl_m = 1'b0; idle(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; idle(Q);
        scl_m = 1'b1; idle(Q);
        sda_m = 1'b1; idle(2*Q);
    endtask

    task automatic clk_bit(input logic b, output logic s);
        sda_m = b;    idle(Q);
        scl_m = 1'b1; idle(Q);
        s = sda_bus;  idle(Q);
        scl_m = 1'b0; idle(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic d;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], d);
        clk_bit(1'b1, ack);
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] d);
        logic x;
        for (int i = 7; i >= 0; i--) clk_bit(1'b1, d[i]);
        clk_bit(nack, x);
        sda_m = 1'b1;
    endtask

    task automatic chk_outs(input string req, input logic [7:0] v0, input logic [7:0] v1);
        chk(req, "buf_en", buf_en, v0);
        chk(req, "cpu/asic/pci", {cpu_en, asic_en, pci_en}, v1[6:0]);
    endtask

    task automatic write_txn(input logic [7:0] cmd, input logic [7:0] cnt,
                             input logic [7:0] v0, input logic [7:0] v1);
        logic a;
        bus_start();
        send_byte(8'hD2, a); chk("R2", "write addr ack", a, 0);
        send_byte(cmd, a);   chk("R3", "cmd ack", a, 0);
        send_byte(cnt, a);   chk("R3", "count ack", a, 0);
        send_byte(v0, a);    chk("R3", "byte0 ack", a, 0);
        send_byte(v1, a);    chk("R3", "byte1 ack", a, 0);
        send_byte(~v0, a);   chk("R7", "extra ack", a, 0);
        bus_stop();
    endtask

    task automatic read_txn(input logic [7:0] e0, input logic [7:0] e1);
        logic       a;
        logic [7:0] d;
        bus_start();
        send_byte(8'hD3, a); chk("R2", "read addr ack", a, 0);
        recv_byte(1'b0, d);  chk("R6", "count byte", d, 8'h09);
        recv_byte(1'b0, d);  chk("R6", "byte0 read", d, e0);
        recv_byte(1'b0, d);  chk("R5", "byte1 read", d, e1);
        recv_byte(1'b1, d);  chk("R6", "beyond read", d, 8'h00);
        bus_stop();
    endtask

    initial begin
        logic       a;
        logic [7:0] d, v0, v1;
        idle(5);
        rst_n = 1'b1;
        idle(3);
        // R1 reset state
        chk_outs("R1", 8'hFF, 8'h7F);
        chk("R1", "sda_oe", sda_oe, 0);
        read_txn(8'hFF, 8'h7F);

        // R4 R5 R3 R7: walking one and walking zero through both bytes
        for (int k = 0; k < 16; k++) begin
            v0 = 8'h01 << (k % 8);
            if (k >= 8) v0 = ~v0;
            v1 = ~v0;
            write_txn(8'(k * 37), 8'(8'hA5 ^ k), v0, v1);
            chk_outs("R4", v0, v1);
            read_txn(v0, v1 & 8'h7F);
        end

        // R2: every other address is ignored
        write_txn(8'h00, 8'h00, 8'h5A, 8'hC3);
        for (int ad = 0; ad < 128; ad++) begin
            if (ad != 7'h69) begin
                bus_start();
                send_byte({7'(ad), 1'(ad)}, a); chk("R2", "foreign addr nack", a, 1);
                send_byte(8'h00, a);            chk("R2", "foreign data nack", a, 1);
                bus_stop();
            end
        end
        chk_outs("R2", 8'h5A, 8'h43);

        // R8: master NACK ends the read, later clocks are ignored
        bus_start();
        send_byte(8'hD3, a); chk("R2", "read addr ack", a, 0);
        recv_byte(1'b1, d);  chk("R8", "count before nack", d, 8'h09);
        recv_byte(1'b1, d);  chk("R8", "silent after nack", d, 8'hFF);
        chk("R8", "sda_oe after nack", sda_oe, 0);
        bus_stop();

        // R9: repeated START restarts with the count byte
        bus_start();
        send_byte(8'hD2, a); send_byte(8'h11, a); send_byte(8'h22, a);
        bus_start();
        send_byte(8'hD3, a); chk("R9", "restart addr ack", a, 0);
        recv_byte(1'b0, d);  chk("R9", "restart count", d, 8'h09);
        recv_byte(1'b1, d);  chk("R9", "restart byte0", d, 8'h5A);
        bus_stop();

        // R9: STOP in the middle of a data byte leaves the registers alone
        bus_start();
        send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h09, a);
        for (int i = 0; i < 4; i++) clk_bit(1'b0, a);
        bus_stop();
        chk("R9", "sda_oe after stop", sda_oe, 0);
        chk_outs("R9", 8'h5A, 8'h43);
        read_txn(8'h5A, 8'h43);

        // R5: bit 7 of byte 1 is not writable
        write_txn(8'h00, 8'h09, 8'h00, 8'h80);
        chk_outs("R5", 8'h00, 8'h00);
        read_txn(8'h00, 8'h00);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 200000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule